// File: doc/BRIEF.md
# Transparent Address Window Matcher

This block decides, for every access, whether the address falls inside one of two address windows that bypass page translation. It holds four window registers: a pair for data accesses and a pair for instruction accesses. The function code of the access picks the pair. Each window carries a base value and an ignore mask for the top address byte, an enable bit and a write-protect bit. When an enabled window of the chosen pair covers the address, the block reports a hit. On a hit the physical address equals the logical address, and the block raises a write-protect fault if a protected window is written outside probe mode.

The result is registered, so it appears one clock after the access. Software-side logic loads the window registers through a simple write port. A write lands at the clock edge, so an access in the same cycle still sees the old contents.

Top module: `xlat_bypass_unit`

## Requirements
- R1: After synchronous reset every output is zero, and all four window registers hold zero, so no window is enabled and no access hits.
- R2: The function code picks the window pair. If bit 0 is set, the data pair is used (cfg_sel 0 and 1). Otherwise, if bit 1 is set, the instruction pair is used (cfg_sel 2 and 3). Bit 2 has no effect on matching.
- R3: A window takes part in matching only while bit 15 of its register is 1.
- R4: Register bits 31:24 hold the base and bits 23:16 hold an ignore mask. A 1 in the mask excludes that address bit from the compare. A window matches when address bits 31:24 equal the base on every bit that is not excluded.
- R5: Window 0 of a pair takes priority over window 1. hit_win reports the index of the window that won, and only that window's protect bit is used.
- R6: On a hit, phys_addr equals the access address unchanged. Without a hit, phys_addr is zero.
- R7: If the winning window has bit 2 set and the access is a write (acc_wr = 1), wp_fault is 1. A read never faults.
- R8: While acc_probe is 1, wp_fault stays 0 even for a write to a protected window. hit is still reported.
- R9: A function code with bits 1:0 both zero gives bad_fc = 1 and no hit.
- R10: Results appear one clock after acc_valid, with out_valid = 1. Without acc_valid, hit, wp_fault and bad_fc are 0.
- R11: A write with cfg_we = 1 loads register cfg_sel from cfg_wdata at the clock edge. An access in the same cycle uses the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Logical address |
| acc_fc | input | 3 | Function code |
| acc_wr | input | 1 | 1 = write access |
| acc_probe | input | 1 | Probe mode, suppresses faults |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 2 | Window register index |
| cfg_wdata | input | 32 | Window register write data |
| out_valid | output | 1 | Registered result valid |
| hit | output | 1 | Address inside an enabled window |
| hit_win | output | 1 | Index of the winning window |
| phys_addr | output | 32 | Bypass address, zero on a miss |
| wp_fault | output | 1 | Write-protect fault |
| bad_fc | output | 1 | Function code selects no pair |

## Verification
The hardest case to reach from the ports is two enabled windows of the same pair that both cover one address, with only the lower-priority window protected. To reach it, the stimulus programs overlapping windows of different mask widths and then disables window 0 between accesses, so the winner changes. A second hard case is a register write that lands in the same cycle as an access to the window being changed. The stimulus drives both in one cycle, and the cycle-accurate model expects the old contents. Random register loads drawn from a small set of top bytes and masks keep overlaps frequent.

// File: rtl/xlat_bypass_pkg.sv
package xlat_bypass_pkg;
  // bit position of the write-protect flag inside a window register
  localparam int WP_POS = 2;

  typedef enum logic [1:0] {
    PAIR_NONE  = 2'd0,
    PAIR_DATA  = 2'd1,
    PAIR_INSTR = 2'd2
  } pair_sel_e;
endpackage

// File: rtl/xlat_win_regs.sv
module xlat_win_regs #(
  parameter int REG_W = 32,
  parameter int WINS  = 2,
  localparam int TOTAL = 2 * WINS,
  localparam int SEL_W = $clog2(TOTAL)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [SEL_W-1:0]           cfg_sel,
  input  logic [REG_W-1:0]           cfg_wdata,
  output logic [WINS-1:0][REG_W-1:0] data_words,
  output logic [WINS-1:0][REG_W-1:0] instr_words
);
  logic [TOTAL-1:0][REG_W-1:0] word_q;

  for (genvar i = 0; i < TOTAL; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[i] <= '0;
      end else if (cfg_we && (cfg_sel == SEL_W'(i))) begin
        word_q[i] <= cfg_wdata;
      end
    end
  end

  for (genvar j = 0; j < WINS; j++) begin : g_split
    assign data_words[j]  = word_q[j];
    assign instr_words[j] = word_q[WINS + j];
  end
endmodule

// File: rtl/xlat_win_cmp.sv
module xlat_win_cmp #(
  parameter int ADDR_W = 32,
  parameter int CMP_W  = 8,
  localparam int HI     = ADDR_W - 1,
  localparam int EN_POS = ADDR_W - 2 * CMP_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] word,
  output logic              match,
  output logic              prot
);
  import xlat_bypass_pkg::*;

  logic [CMP_W-1:0] base_f;
  logic [CMP_W-1:0] ignore_f;
  logic [CMP_W-1:0] diff;
  logic             unused_fields;

  assign base_f   = word[HI -: CMP_W];
  assign ignore_f = word[HI-CMP_W -: CMP_W];
  assign diff     = (addr[HI -: CMP_W] ^ base_f) & ~ignore_f;
  assign match    = word[EN_POS] && (diff == '0);
  assign prot     = word[WP_POS];

  assign unused_fields = ^{word[EN_POS-1:WP_POS+1], word[WP_POS-1:0],
                           addr[HI-CMP_W:0]};
endmodule

// File: rtl/xlat_win_prio.sv
module xlat_win_prio #(
  parameter int WINS = 2,
  localparam int IDX_W = (WINS > 1) ? $clog2(WINS) : 1
) (
  input  logic [WINS-1:0]  match_v,
  input  logic [WINS-1:0]  prot_v,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic             prot
);
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    prot = 1'b0;
    // scan from the highest index down so the lowest index wins
    for (int w = WINS - 1; w >= 0; w--) begin
      if (match_v[w]) begin
        any  = 1'b1;
        idx  = IDX_W'(w);
        prot = prot_v[w];
      end
    end
  end
endmodule

// File: rtl/xlat_bypass_unit.sv
module xlat_bypass_unit #(
  parameter int ADDR_W = 32,
  parameter int CMP_W  = 8,
  parameter int FC_W   = 3,
  parameter int WINS   = 2,
  localparam int SEL_W = $clog2(2 * WINS),
  localparam int IDX_W = (WINS > 1) ? $clog2(WINS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [FC_W-1:0]   acc_fc,
  input  logic              acc_wr,
  input  logic              acc_probe,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              out_valid,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_win,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              wp_fault,
  output logic              bad_fc
);
  import xlat_bypass_pkg::*;

  logic [WINS-1:0][ADDR_W-1:0] data_words;
  logic [WINS-1:0][ADDR_W-1:0] instr_words;
  logic [WINS-1:0][ADDR_W-1:0] pick_words;
  logic [WINS-1:0]             raw_match;
  logic [WINS-1:0]             raw_prot;
  logic [WINS-1:0]             gated_match;
  logic                        any_hit;
  logic [IDX_W-1:0]            win_idx;
  logic                        win_prot;
  pair_sel_e                   pair;
  logic                        unused_fc;

  xlat_win_regs #(.REG_W(ADDR_W), .WINS(WINS)) regs_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .data_words  (data_words),
    .instr_words (instr_words)
  );

  always_comb begin
    if (acc_fc[0])      pair = PAIR_DATA;
    else if (acc_fc[1]) pair = PAIR_INSTR;
    else                pair = PAIR_NONE;
  end

  always_comb begin
    case (pair)
      PAIR_DATA:  pick_words = data_words;
      PAIR_INSTR: pick_words = instr_words;
      default:    pick_words = '0;
    endcase
  end

  for (genvar w = 0; w < WINS; w++) begin : g_cmp
    xlat_win_cmp #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) cmp_i (
      .addr  (acc_addr),
      .word  (pick_words[w]),
      .match (raw_match[w]),
      .prot  (raw_prot[w])
    );
  end

  assign gated_match = (pair == PAIR_NONE) ? '0 : raw_match;

  xlat_win_prio #(.WINS(WINS)) prio_i (
    .match_v (gated_match),
    .prot_v  (raw_prot),
    .any     (any_hit),
    .idx     (win_idx),
    .prot    (win_prot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      hit       <= 1'b0;
      hit_win   <= '0;
      phys_addr <= '0;
      wp_fault  <= 1'b0;
      bad_fc    <= 1'b0;
    end else begin
      out_valid <= acc_valid;
      hit       <= acc_valid && any_hit;
      hit_win   <= (acc_valid && any_hit) ? win_idx : '0;
      phys_addr <= (acc_valid && any_hit) ? acc_addr : '0;
      wp_fault  <= acc_valid && any_hit && win_prot && acc_wr && !acc_probe;
      bad_fc    <= acc_valid && (pair == PAIR_NONE);
    end
  end

  if (FC_W > 2) begin : g_fc_hi
    assign unused_fc = ^acc_fc[FC_W-1:2];
  end else begin : g_fc_none
    assign unused_fc = 1'b0;
  end
endmodule

// File: rtl/xlat_bypass_chk.sv
module xlat_bypass_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        fc_lo,
  input logic              acc_wr,
  input logic              acc_probe,
  input logic              out_valid,
  input logic              hit,
  input logic [ADDR_W-1:0] phys_addr,
  input logic              wp_fault,
  input logic              bad_fc
);
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(acc_valid)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!hit && !bad_fc && !wp_fault));

  p_pass_addr_r6: assert property (@(posedge clk) disable iff (rst)
    hit |-> (phys_addr == $past(acc_addr)));

  p_miss_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (phys_addr == '0));

  p_fault_write_r7: assert property (@(posedge clk) disable iff (rst)
    wp_fault |-> (hit && $past(acc_wr)));

  p_probe_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    wp_fault |-> !$past(acc_probe));

  p_bad_fc_r9: assert property (@(posedge clk) disable iff (rst)
    bad_fc |-> (!hit && ($past(fc_lo) == 2'b00)));
endmodule

bind xlat_bypass_unit xlat_bypass_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_addr  (acc_addr),
  .fc_lo     (acc_fc[1:0]),
  .acc_wr    (acc_wr),
  .acc_probe (acc_probe),
  .out_valid (out_valid),
  .hit       (hit),
  .phys_addr (phys_addr),
  .wp_fault  (wp_fault),
  .bad_fc    (bad_fc)
);

// File: tb/xlat_bypass_unit_tb.sv
`timescale 1ns/1ps
module xlat_bypass_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [2:0]  acc_fc = '0;
  logic        acc_wr = 1'b0;
  logic        acc_probe = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        out_valid, hit, hit_win, wp_fault, bad_fc;
  logic [31:0] phys_addr;

  always #4 clk = ~clk;

  xlat_bypass_unit dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_fc(acc_fc), .acc_wr(acc_wr), .acc_probe(acc_probe),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .hit(hit), .hit_win(hit_win),
    .phys_addr(phys_addr), .wp_fault(wp_fault), .bad_fc(bad_fc)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    started = 0;
  bit    done = 0;

  // behavioural reference
  logic [31:0] m_reg [4];
  logic        e_valid, e_hit, e_win, e_fault, e_bad;
  logic [31:0] e_addr;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      for (int k = 0; k < 4; k++) m_reg[k] = '0;
      {e_valid, e_hit, e_win, e_fault, e_bad} = '0;
      e_addr = '0;
    end else begin
      int  first;
      int  base_i;
      bit  pick;
      first = -1;
      pick = 1'b1;
      if (acc_fc[0]) base_i = 0;
      else if (acc_fc[1]) base_i = 2;
      else begin base_i = 0; pick = 1'b0; end
      if (pick) begin
        for (int w = 1; w >= 0; w--) begin
          logic [31:0] r;
          logic [7:0]  keep;
          r = m_reg[base_i + w];
          keep = ~r[23:16];
          if (r[15] && ((acc_addr[31:24] & keep) == (r[31:24] & keep))) first = w;
        end
      end
      e_valid = acc_valid;
      e_bad   = acc_valid && !pick;
      e_hit   = acc_valid && (first >= 0);
      e_win   = e_hit ? first[0] : 1'b0;
      e_addr  = e_hit ? acc_addr : 32'h0;
      e_fault = e_hit && m_reg[base_i + first][2] && acc_wr && !acc_probe;
      if (cfg_we) m_reg[cfg_sel] = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if ({out_valid, hit, hit_win, wp_fault, bad_fc, phys_addr} !==
          {e_valid, e_hit, e_win, e_fault, e_bad, e_addr}) begin
        errors++;
        $display("FAIL %s: got v=%0b hit=%0b win=%0b wp=%0b bad=%0b pa=%08h exp v=%0b hit=%0b win=%0b wp=%0b bad=%0b pa=%08h",
                 tag, out_valid, hit, hit_win, wp_fault, bad_fc, phys_addr,
                 e_valid, e_hit, e_win, e_fault, e_bad, e_addr);
      end
    end
  end

  task automatic idle();
    acc_valid = 0; cfg_we = 0;
    @(negedge clk);
  endtask

  task automatic acc(input logic [31:0] a, input logic [2:0] fc,
                     input logic wr, input logic pr);
    acc_valid = 1; acc_addr = a; acc_fc = fc; acc_wr = wr; acc_probe = pr;
    cfg_we = 0;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic cfg(input logic [1:0] s, input logic [31:0] d);
    acc_valid = 0; cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // explicit check of the registered result one cycle after an access
  task automatic expect_out(input string t, input logic h, input logic wv,
                            input logic f, input logic b);
    checks++;
    if ({hit, hit_win, wp_fault, bad_fc} !== {h, wv, f, b}) begin
      errors++;
      $display("FAIL %s: got hit=%0b win=%0b wp=%0b bad=%0b exp hit=%0b win=%0b wp=%0b bad=%0b",
               t, hit, hit_win, wp_fault, bad_fc, h, wv, f, b);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R1";
    expect_out("R1", 0, 0, 0, 0);
    acc(32'h4512_3456, 3'd1, 0, 0); expect_out("R1", 0, 0, 0, 0);
    acc(32'h0000_0000, 3'd2, 1, 0); expect_out("R1", 0, 0, 0, 0);

    tag = "R4";
    cfg(2'd0, 32'h400F_8000);
    acc(32'h4512_3456, 3'd1, 0, 0); expect_out("R4", 1, 0, 0, 0);
    acc(32'h5012_3456, 3'd1, 0, 0); expect_out("R4", 0, 0, 0, 0);
    acc(32'h4F00_0000, 3'd5, 1, 0); expect_out("R4", 1, 0, 0, 0);

    tag = "R2";
    acc(32'h4512_3456, 3'd2, 0, 0); expect_out("R2", 0, 0, 0, 0);
    cfg(2'd3, 32'h8000_8004);
    acc(32'h80AB_CDEF, 3'd6, 0, 0); expect_out("R2", 1, 1, 0, 0);
    acc(32'h80AB_CDEF, 3'd3, 0, 0); expect_out("R2", 0, 0, 0, 0);

    tag = "R7";
    acc(32'h80AB_CDEF, 3'd2, 1, 0); expect_out("R7", 1, 1, 1, 0);
    tag = "R8";
    acc(32'h80AB_CDEF, 3'd2, 1, 1); expect_out("R8", 1, 1, 0, 0);

    tag = "R3";
    cfg(2'd1, 32'h9000_0004);
    acc(32'h9000_0000, 3'd1, 1, 0); expect_out("R3", 0, 0, 0, 0);
    cfg(2'd1, 32'h9000_8004);
    acc(32'h9000_0000, 3'd1, 1, 0); expect_out("R3", 1, 1, 1, 0);

    tag = "R5";
    cfg(2'd1, 32'h4000_8004);
    acc(32'h4000_0010, 3'd1, 1, 0); expect_out("R5", 1, 0, 0, 0);
    cfg(2'd0, 32'h400F_0000);
    acc(32'h4000_0010, 3'd1, 1, 0); expect_out("R5", 1, 1, 1, 0);

    tag = "R9";
    acc(32'h4000_0010, 3'd0, 1, 0); expect_out("R9", 0, 0, 0, 1);
    acc(32'h8000_0000, 3'd4, 0, 0); expect_out("R9", 0, 0, 0, 1);

    tag = "R11";
    acc_valid = 1; acc_addr = 32'h80AB_CDEF; acc_fc = 3'd2; acc_wr = 0; acc_probe = 0;
    cfg_we = 1; cfg_sel = 2'd3; cfg_wdata = 32'h8000_0000;
    @(negedge clk);
    expect_out("R11", 1, 1, 0, 0);
    cfg_we = 0;
    acc(32'h80AB_CDEF, 3'd2, 0, 0); expect_out("R11", 0, 0, 0, 0);

    tag = "R10";
    idle(); expect_out("R10", 0, 0, 0, 0);

    tag = "R6";
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] tops [6];
      logic [7:0] masks [4];
      tops  = '{8'h40, 8'h41, 8'h4C, 8'h80, 8'hC0, 8'h81};
      masks = '{8'h00, 8'h0F, 8'h3F, 8'h01};
      if ($urandom_range(0, 5) == 0) begin
        cfg_we = 1;
        cfg_sel = 2'($urandom_range(0, 3));
        cfg_wdata = {tops[$urandom_range(0, 5)], masks[$urandom_range(0, 3)],
                     1'($urandom_range(0, 3) != 0), 12'($urandom),
                     1'($urandom), 2'($urandom)};
      end else begin
        cfg_we = 0;
      end
      acc_valid = 1'($urandom_range(0, 4) != 0);
      acc_addr  = {tops[$urandom_range(0, 5)], 24'($urandom)};
      acc_fc    = 3'($urandom);
      acc_wr    = 1'($urandom);
      acc_probe = ($urandom_range(0, 3) == 0);
      @(negedge clk);
    end
    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule